// File: doc/BRIEF.md
# Phase Build-Out Corrector for Reference Switching

This block sits between the selected timing reference and the phase detector of a digital PLL. Every reference edge arrives as a one-cycle strobe in a fast system-clock domain. The block re-emits each edge as a virtual reference strobe after a programmable delay, counted in system-clock ticks. While the delay stays fixed, the PLL tracks the reference through a constant phase offset.

When the control state machine raises the correction enable during a reference rearrangement, the block measures a new delay once. It counts the ticks from the next reference edge to the next PLL feedback edge, and the count restarts at every reference edge, so the result is taken modulo the reference period. The measured count becomes the new delay. After that the delayed reference lands on the feedback phase, so the phase step caused by the switch never reaches the PLL.

Outside a measurement the delay is frozen. An active-low clear input forces the delay back to zero, which realigns output phase with input phase. Pending edges wait in a small timestamp queue, so each edge keeps the delay that was in force when it arrived.

Top module: `pbo_tie_corrector`

## Requirements
- R1: After reset, `delay_val` is 0, `vref_edge` is low and no edge is pending.
- R2: A `ref_edge` strobe sampled in cycle k produces a one-cycle `vref_edge` pulse in cycle k+D+2, where D is `delay_val` in cycle k, provided no earlier pending edge blocks it.
- R3: With `corr_en` high, a measurement is armed one cycle after the meter is idle. The first `ref_edge` after arming starts a tick count at 0. Each further `ref_edge` restarts the count at 0, and each other cycle adds 1. The `fb_edge` that follows loads the count into `delay_val` in the next cycle. A `fb_edge` in the same cycle as the starting `ref_edge` loads 0.
- R4: Only one measurement is made per assertion of `corr_en`. After a load, `delay_val` holds regardless of further edges until `corr_en` has been low for at least one cycle and rises again. While `corr_en` is low, `delay_val` does not change.
- R5: Dropping `corr_en` before the feedback edge abandons the measurement and leaves `delay_val` unchanged.
- R6: `clr_n` low in cycle k makes `delay_val` 0 in cycle k+1. This overrides a load in the same cycle and abandons any measurement. No new measurement starts until `corr_en` has gone low.
- R7: Pending edges leave in arrival order, at most one per cycle. An edge whose due cycle passes while an older edge is still waiting leaves in the first cycle after the older edges have gone.
- R8: The queue holds QDEPTH pending edges. A `ref_edge` arriving when the queue is full and no edge leaves in that cycle is dropped.
- R9: The tick count saturates at 2^DLY_W-1, so a feedback edge that comes later than that loads the maximum value.
- R10: Once a correction has loaded D, and for a reference and feedback of equal period, each `vref_edge` comes exactly 2 cycles after the matching `fb_edge`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_n | input | 1 | Correction clear, active low, forces the delay to zero |
| corr_en | input | 1 | Correction enable from the control state machine |
| ref_edge | input | 1 | One-cycle strobe per selected reference edge |
| fb_edge | input | 1 | One-cycle strobe per PLL feedback edge |
| vref_edge | output | 1 | One-cycle strobe per delayed (virtual) reference edge |
| delay_val | output | DLY_W | Delay in ticks currently applied to new reference edges |

## Verification
Assertions check on every cycle that a clear zeroes the delay on the next cycle and that the delay holds while the enable is low or no feedback edge occurs. They also check that the queue never exceeds its depth, that a full queue stays full when an edge is dropped, and that no pulse is emitted from an empty queue. Only the bench's scenarios can show that the measured values and the D+2 emission timing are right. The same holds for the one-shot behaviour per enable assertion, the backlog ordering after a delay reduction, the dropping of edges, saturation of the count, and the alignment of the virtual reference to the feedback after a phase step.

// File: rtl/pbo_pkg.sv
package pbo_pkg;

   // Measurement controller states of the phase meter
   typedef enum logic [1:0] {
      MS_IDLE  = 2'd0,   // waiting for the correction enable
      MS_ARMED = 2'd1,   // enabled, waiting for the first reference edge
      MS_MEAS  = 2'd2,   // counting ticks towards a feedback edge
      MS_HOLD  = 2'd3    // result loaded or cleared, waits for enable low
   } meter_state_t;

   // Timestamp width needed for a given delay width: one bit for the
   // extra pipeline tick and one sign bit for wrap-safe comparison.
   function automatic int stamp_width(input int dly_w);
      return dly_w + 2;
   endfunction

endpackage

// File: rtl/pbo_stamp_timer.sv
module pbo_stamp_timer #(
   parameter int TS_W = 14
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [TS_W-1:0] now
);

   if (TS_W < 3) begin : g_bad_width
      $error("pbo_stamp_timer: TS_W must be at least 3");
   end

   // Free-running tick counter; wraps silently, comparisons are modular
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         now <= '0;
      end else begin
         now <= now + TS_W'(1);
      end
   end

endmodule

// File: rtl/pbo_edge_queue.sv
module pbo_edge_queue #(
   parameter int TS_W  = 14,
   parameter int DEPTH = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [TS_W-1:0]              now,
   input  logic                         push,
   input  logic [TS_W-1:0]              push_due,
   output logic                         fire,
   output logic [$clog2(DEPTH+1)-1:0]   level
);

   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 1) begin : g_bad_depth
      $error("pbo_edge_queue: DEPTH must be at least 1");
   end
   if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_pow2
      $error("pbo_edge_queue: DEPTH must be a power of two");
   end

   logic [TS_W-1:0] slot_due [DEPTH];
   logic [PW-1:0]   rd_ptr;
   logic [PW-1:0]   wr_ptr;
   logic [CW-1:0]   cnt;
   logic [TS_W-1:0] head_due;
   logic [TS_W-1:0] lag;
   logic            head_ready;
   logic            pop;
   logic            accept;
   logic            is_full;

   assign head_due   = slot_due[rd_ptr];
   assign lag        = now - head_due;
   // The head is due when the signed lag is not negative
   assign head_ready = (cnt != '0) && !lag[TS_W-1];
   assign pop        = head_ready;
   assign is_full    = (cnt == CW'(DEPTH));
   assign accept     = push && (!is_full || pop);

   // Storage: one register per slot
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [TS_W-1:0] due_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            due_r <= '0;
         end else if (accept && (wr_ptr == PW'(i))) begin
            due_r <= push_due;
         end
      end
      assign slot_due[i] = due_r;
   end

   // Pointer handling: a single slot needs no pointers at all
   if (DEPTH == 1) begin : g_single
      assign rd_ptr = '0;
      assign wr_ptr = '0;
   end else begin : g_ring
      logic [PW-1:0] rd_r;
      logic [PW-1:0] wr_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_r <= '0;
            wr_r <= '0;
         end else begin
            if (pop) begin
               rd_r <= rd_r + PW'(1);
            end
            if (accept) begin
               wr_r <= wr_r + PW'(1);
            end
         end
      end
      assign rd_ptr = rd_r;
      assign wr_ptr = wr_r;
   end

   // Occupancy and registered output strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         fire <= 1'b0;
      end else begin
         fire <= pop;
         case ({accept, pop})
            2'b10:   cnt <= cnt + CW'(1);
            2'b01:   cnt <= cnt - CW'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   assign level = cnt;

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH)); // R8

   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (push && is_full && !head_ready) |=> (cnt == CW'(DEPTH))); // R8

   AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0) |=> !fire); // R7

endmodule

// File: rtl/pbo_phase_meter.sv
module pbo_phase_meter #(
   parameter int DLY_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_n,
   input  logic             corr_en,
   input  logic             ref_edge,
   input  logic             fb_edge,
   output logic [DLY_W-1:0] delay_q
);

   import pbo_pkg::*;

   localparam logic [DLY_W-1:0] CNT_MAX = {DLY_W{1'b1}};

   if (DLY_W < 2) begin : g_bad_width
      $error("pbo_phase_meter: DLY_W must be at least 2");
   end

   meter_state_t     st, st_n;
   logic [DLY_W-1:0] cnt, cnt_n;
   logic [DLY_W-1:0] dly_n;
   logic [DLY_W-1:0] elapsed;
   logic             counting;

   function automatic logic [DLY_W-1:0] sat_inc(input logic [DLY_W-1:0] v);
      return (v == CNT_MAX) ? CNT_MAX : v + DLY_W'(1);
   endfunction

   // Ticks since the latest reference edge, including this cycle
   assign elapsed  = ref_edge ? '0 : sat_inc(cnt);
   assign counting = (st == MS_MEAS) || ((st == MS_ARMED) && ref_edge);

   always_comb begin
      st_n  = st;
      cnt_n = cnt;
      dly_n = delay_q;
      if (!clr_n) begin
         dly_n = '0;
         st_n  = MS_HOLD;
      end else begin
         case (st)
            MS_IDLE: begin
               if (corr_en) begin
                  st_n = MS_ARMED;
               end
            end
            MS_ARMED, MS_MEAS: begin
               if (!corr_en) begin
                  st_n = MS_IDLE;
               end else if (counting) begin
                  if (fb_edge) begin
                     dly_n = elapsed;
                     st_n  = MS_HOLD;
                  end else begin
                     cnt_n = elapsed;
                     st_n  = MS_MEAS;
                  end
               end
            end
            MS_HOLD: begin
               if (!corr_en) begin
                  st_n = MS_IDLE;
               end
            end
            default: st_n = MS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= MS_IDLE;
         cnt     <= '0;
         delay_q <= '0;
      end else begin
         st      <= st_n;
         cnt     <= cnt_n;
         delay_q <= dly_n;
      end
   end

   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |=> (delay_q == '0)); // R6

   AST_LOAD_ONLY_ON_FB: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && !fb_edge) |=> $stable(delay_q)); // R3

   AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && !corr_en) |=> $stable(delay_q)); // R4

   AST_HOLD_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == MS_HOLD) && corr_en) |=> (st != MS_MEAS)); // R4

endmodule

// File: rtl/pbo_tie_corrector.sv
module pbo_tie_corrector #(
   parameter int DLY_W  = 12,
   parameter int QDEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_n,
   input  logic             corr_en,
   input  logic             ref_edge,
   input  logic             fb_edge,
   output logic             vref_edge,
   output logic [DLY_W-1:0] delay_val
);

   localparam int TS_W = pbo_pkg::stamp_width(DLY_W);
   localparam int LW   = $clog2(QDEPTH + 1);

   if (QDEPTH < 2) begin : g_shallow
      $error("pbo_tie_corrector: QDEPTH must be at least 2 to hold an edge in flight while the next one arrives");
   end

   logic [TS_W-1:0]  now;
   logic [TS_W-1:0]  due;
   logic [DLY_W-1:0] dly;
   logic [LW-1:0]    level;

   pbo_stamp_timer #(.TS_W(TS_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .now   (now)
   );

   pbo_phase_meter #(.DLY_W(DLY_W)) u_meter (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_n    (clr_n),
      .corr_en  (corr_en),
      .ref_edge (ref_edge),
      .fb_edge  (fb_edge),
      .delay_q  (dly)
   );

   // Due stamp: one tick through the queue plus the programmed delay
   assign due = now + TS_W'(dly) + TS_W'(1);

   pbo_edge_queue #(.TS_W(TS_W), .DEPTH(QDEPTH)) u_queue (
      .clk      (clk),
      .rst_n    (rst_n),
      .now      (now),
      .push     (ref_edge),
      .push_due (due),
      .fire     (vref_edge),
      .level    (level)
   );

   assign delay_val = dly;

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (level == '0)); // R1

endmodule

// File: tb/pbo_tie_corrector_test.sv
module pbo_tie_corrector_test;

   localparam int DW   = 6;
   localparam int QD   = 4;
   localparam int MAXD = (1 << DW) - 1;
   localparam int PER  = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clr_n = 1'b1;
   logic          corr_en = 1'b0;
   logic          ref_edge = 1'b0;
   logic          fb_edge = 1'b0;
   logic          vref_edge;
   logic [DW-1:0] delay_val;

   int n_tests = 0;
   int n_fail  = 0;
   int gcyc    = 0;
   int last_ref = -1, last_fb = -1, last_vref = -1;
   int pulses  = 0;
   int rp = 0, fp = 7;
   string cur_req = "R1";
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   pbo_tie_corrector #(.DLY_W(DW), .QDEPTH(QD)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_n     (clr_n),
      .corr_en   (corr_en),
      .ref_edge  (ref_edge),
      .fb_edge   (fb_edge),
      .vref_edge (vref_edge),
      .delay_val (delay_val)
   );

   // Behavioural reference model, advanced on every clock
   int m_q[$];
   int m_delay = 0, m_st = 0, m_cnt = 0, m_tick = 0;
   bit m_vref = 1'b0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_q.delete();
         m_delay = 0; m_st = 0; m_cnt = 0; m_tick = 0; m_vref = 1'b0;
      end else begin
         bit nv;
         int el;
         nv = 1'b0;
         if (m_q.size() > 0 && m_q[0] <= m_tick) begin
            void'(m_q.pop_front());
            nv = 1'b1;
         end
         if (ref_edge && m_q.size() < QD) m_q.push_back(m_tick + m_delay + 1);
         el = ref_edge ? 0 : ((m_cnt < MAXD) ? m_cnt + 1 : MAXD);
         if (!clr_n) begin
            m_delay = 0; m_st = 3;
         end else begin
            case (m_st)
               0: if (corr_en) m_st = 1;
               1, 2: begin
                  if (!corr_en) m_st = 0;
                  else if (m_st == 2 || ref_edge) begin
                     if (fb_edge) begin m_delay = el; m_st = 3; end
                     else begin m_cnt = el; m_st = 2; end
                  end
               end
               default: if (!corr_en) m_st = 0;
            endcase
         end
         m_vref = nv;
         m_tick++;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, gcyc);
      end
   endtask

   task automatic step(input bit r, input bit f);
      @(negedge clk);
      if (rst_n) begin
         chk(vref_edge == m_vref, cur_req, int'(vref_edge), int'(m_vref));
         chk(int'(delay_val) == m_delay, cur_req, int'(delay_val), m_delay);
      end
      if (vref_edge) begin last_vref = gcyc; pulses++; end
      ref_edge = r; fb_edge = f;
      if (r) last_ref = gcyc;
      if (f) last_fb = gcyc;
      gcyc++;
   endtask

   task automatic run_n(input int n);
      for (int i = 0; i < n; i++) step((gcyc % PER) == rp, (gcyc % PER) == fp);
   endtask

   task automatic run(input int n);
      run_n(n);
      while ((gcyc % PER) != 0) run_n(1);
   endtask

   task automatic rearm();
      corr_en = 1'b0; run(1);
      corr_en = 1'b1;
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      repeat (3) step(0, 0);
      rst_n = 1'b1;
      // R1: reset state
      chk(vref_edge == 1'b0, "R1", int'(vref_edge), 0);
      chk(delay_val == '0, "R1", int'(delay_val), 0);
      while ((gcyc % PER) != 0) step(0, 0);

      // R2: zero delay, pulse two cycles after the reference edge
      cur_req = "R2"; rp = 0; fp = 7;
      run(60);
      chk(last_vref - last_ref == 2, "R2", last_vref - last_ref, 2);

      // R3 and R10: measurement loads the reference-to-feedback distance
      cur_req = "R3"; corr_en = 1'b1;
      run(60);
      chk(delay_val == DW'(7), "R3", int'(delay_val), 7);
      chk(last_vref - last_fb == 2, "R10", last_vref - last_fb, 2);

      // R4: one measurement per enable assertion
      cur_req = "R4"; fp = 12;
      run(60);
      chk(delay_val == DW'(7), "R4", int'(delay_val), 7);
      rearm(); run(60);
      chk(delay_val == DW'(12), "R4", int'(delay_val), 12);

      // R3: phase step on the reference, new measurement absorbs it
      cur_req = "R3"; rp = 5;
      rearm(); run(60);
      chk(delay_val == DW'(7), "R3", int'(delay_val), 7);
      chk(last_vref - last_fb == 2, "R10", last_vref - last_fb, 2);

      // R5: enable dropped before the feedback edge
      cur_req = "R5"; fp = 3;
      rearm(); run_n(10);
      corr_en = 1'b0; run(40);
      chk(delay_val == DW'(7), "R5", int'(delay_val), 7);

      // R6: clear in hold, then clear during a measurement
      cur_req = "R6"; fp = 12;
      corr_en = 1'b1; run(40);
      clr_n = 1'b0; run_n(1);
      clr_n = 1'b1; run_n(1);
      chk(delay_val == '0, "R6", int'(delay_val), 0);
      run(60);
      chk(delay_val == '0, "R6", int'(delay_val), 0);
      rearm(); run_n(8);
      clr_n = 1'b0; run_n(1);
      clr_n = 1'b1; run(40);
      chk(delay_val == '0, "R6", int'(delay_val), 0);

      // R7: backlog after the delay is cut while an edge is in flight
      cur_req = "R7"; rp = 0; fp = 16;
      rearm(); run(60);
      chk(delay_val == DW'(16), "R7", int'(delay_val), 16);
      pulses = 0;
      step(1, 0); step(0, 0);
      clr_n = 1'b0; step(0, 0);
      clr_n = 1'b1;
      step(1, 0); step(1, 0); step(1, 0);
      repeat (40) step(0, 0);
      chk(pulses == 4, "R7", pulses, 4);
      while ((gcyc % PER) != 0) step(0, 0);

      // R8: burst into a full queue
      cur_req = "R8";
      rearm(); run(60);
      pulses = 0;
      repeat (8) step(1, 0);
      repeat (40) step(0, 0);
      chk(pulses == QD, "R8", pulses, QD);

      // R9: feedback far beyond the count range
      cur_req = "R9";
      corr_en = 1'b0; step(0, 0);
      corr_en = 1'b1; step(0, 0);
      step(1, 0);
      repeat (100) step(0, 0);
      step(0, 1); step(0, 0); step(0, 0);
      chk(int'(delay_val) == MAXD, "R9", int'(delay_val), MAXD);

      finish_up();
   end

endmodule